// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The block works through a ring of transmit descriptors held in its own small descriptor memory. Each descriptor takes two consecutive 32-bit words. The even word holds the status, the control flags and the frame length. The odd word holds the buffer pointer. Software fills in descriptors through a word-addressed register port and hands each one to hardware by setting its ready flag. The engine then presents the frame length and buffer pointer as a request to a downstream frame-send interface.

When the downstream side reports completion together with a 9-bit result, the engine merges that result into the status word and clears the ready flag. It raises a one-cycle interrupt pulse and a one-cycle fault pulse when they apply, and then moves to the next index. A descriptor with its wrap flag set closes the ring, so the index returns to 0 after it. When the descriptor at the current index is not ready, the engine re-reads it at a fixed polling interval. It never looks past that descriptor to later ones. A low enable parks the engine at index 0.

Top module: `txr_engine`

## Requirements
- R1: After reset, `req_valid`, `irq_pulse` and `err_pulse` are 0, `cur_idx` is 0, and every descriptor word reads 0.
- R2: Descriptor i occupies word address 2*i (status) and 2*i+1 (buffer pointer). A software write takes effect on the next clock, and `sw_rdata` shows the addressed word combinationally.
- R3: When the current descriptor has its ready flag (status bit 15) set, the engine raises `req_valid` with `req_len` equal to status bits 31:16 and `req_ptr` equal to the pointer word. The request stays high and stable until `done_valid`.
- R4: Write-back clears bit 15 and replaces bits 8:0 with `done_status`. Bits 31:16 and 14:9 are preserved. The result layout is: bit 8 underrun, bits 7:4 retry count, bit 3 retry limit, bit 2 late collision, bit 1 deferred, bit 0 carrier lost.
- R5: After write-back the index becomes 0 if the descriptor's wrap flag (status bit 13) was set. Otherwise it increments, and index NUM_DESC-1 is followed by 0.
- R6: A status check that finds the ready flag clear is followed by the next check of the same index no sooner than POLL_GAP (16) cycles later. A ready descriptor at a later index is never served first.
- R7: `irq_pulse` is high for exactly one cycle, the cycle after write-back, when the finished descriptor has status bit 14 set.
- R8: `err_pulse` is high for exactly one cycle, the cycle after write-back, when any of result bits 8, 3, 2, 1 or 0 is set. A nonzero retry count alone raises no fault.
- R9: While `en` is low, `cur_idx` is held at 0 and `req_valid` is 0. An in-flight request is abandoned.
- R10: A software write in the same cycle as a pending write-back wins. The write-back, the index step and the pulses are delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable; low parks at index 0 |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | 7 | Software word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Word at `sw_addr` |
| req_valid | output | 1 | Frame request outstanding |
| req_len | output | 16 | Frame length in bytes |
| req_ptr | output | 32 | Frame buffer pointer |
| done_valid | input | 1 | Downstream completion strobe |
| done_status | input | 9 | Completion result bits |
| irq_pulse | output | 1 | Completion interrupt pulse |
| err_pulse | output | 1 | Completion fault pulse |
| cur_idx | output | 6 | Current descriptor index |

## Verification
The bench times the first poll after enable exactly. A design that polls too often or too late moves the request edge away from the 16th cycle, and one that skips ahead issues a request while the scoreboard queue is empty. Write-back is checked on a word with pad, CRC and wrap flags set, which catches a merge that clobbers control bits. A result carrying only a retry count is used to catch a fault detector that looks at bits 7:4. A software write is collided with the write-back cycle: a design that lets the engine win either loses the software word or fires its pulses a cycle early.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef struct packed {
        logic       underrun;
        logic [3:0] retries;
        logic       retry_lim;
        logic       late_coll;
        logic       deferred;
        logic       carrier_lost;
    } tx_result_t;

    typedef struct packed {
        logic [15:0] len;
        logic        ready;
        logic        irq;
        logic        wrap;
        logic        pad;
        logic        crc;
        logic [1:0]  spare;
        tx_result_t  res;
    } tx_status_t;

    typedef enum logic [1:0] {
        ST_CHECK = 2'd0,
        ST_GAP   = 2'd1,
        ST_BUSY  = 2'd2,
        ST_WB    = 2'd3
    } ring_state_e;

    function automatic tx_status_t merge_result(tx_status_t cur, tx_result_t r);
        tx_status_t o;
        o       = cur;
        o.ready = 1'b0;
        o.res   = r;
        return o;
    endfunction

    function automatic logic is_fault(tx_result_t r);
        return r.underrun | r.retry_lim | r.late_coll | r.deferred | r.carrier_lost;
    endfunction

endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem #(
    parameter int NUM_DESC = 64,
    localparam int DEPTH   = 2 * NUM_DESC,
    localparam int AW      = $clog2(DEPTH),
    localparam int IW      = $clog2(NUM_DESC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_wr,
    input  logic [AW-1:0] sw_addr,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   sw_rdata,
    input  logic [IW-1:0] idx,
    output logic [31:0]   stat_rd,
    output logic [31:0]   ptr_rd,
    input  logic          wb_req,
    input  logic [31:0]   wb_data,
    output logic          wb_done
);
    logic [31:0] mem [DEPTH];

    // Software port has priority; the engine write-back waits a cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (sw_wr) begin
            mem[sw_addr] <= sw_wdata;
        end else if (wb_req) begin
            mem[{idx, 1'b0}] <= wb_data;
        end
    end

    assign sw_rdata = mem[sw_addr];
    assign stat_rd  = mem[{idx, 1'b0}];
    assign ptr_rd   = mem[{idx, 1'b1}];
    assign wb_done  = wb_req & ~sw_wr;
endmodule

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
    parameter int POLL_GAP = 16,
    localparam int CW      = $clog2(POLL_GAP + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    output logic expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(POLL_GAP - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == CW'(1));
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
    import txr_pkg::*;
#(
    parameter int NUM_DESC = 64,
    localparam int IW      = $clog2(NUM_DESC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  tx_status_t    stat,
    input  logic [31:0]   ptr,
    input  logic          done_valid,
    input  tx_result_t    done_res,
    input  logic          wb_done,
    input  logic          gap_expired,
    output logic [IW-1:0] idx,
    output logic          req_valid,
    output logic [15:0]   req_len,
    output logic [31:0]   req_ptr,
    output logic          gap_load,
    output logic          wb_req,
    output logic [31:0]   wb_data,
    output logic          irq_pulse,
    output logic          err_pulse,
    output logic          chk_strobe,
    output logic          chk_hit
);
    ring_state_e state;
    tx_result_t  res_q;

    assign chk_strobe = en && (state == ST_CHECK);
    assign chk_hit    = chk_strobe && stat.ready;
    assign gap_load   = chk_strobe && !stat.ready;
    assign wb_req     = en && (state == ST_WB);
    assign wb_data    = merge_result(stat, res_q);
    assign req_valid  = (state == ST_BUSY);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state     <= ST_CHECK;
            idx       <= '0;
            req_len   <= '0;
            req_ptr   <= '0;
            res_q     <= '0;
            irq_pulse <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            irq_pulse <= 1'b0;
            err_pulse <= 1'b0;
            case (state)
                ST_CHECK: begin
                    if (stat.ready) begin
                        req_len <= stat.len;
                        req_ptr <= ptr;
                        state   <= ST_BUSY;
                    end else begin
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_expired) state <= ST_CHECK;
                end
                ST_BUSY: begin
                    if (done_valid) begin
                        res_q <= done_res;
                        state <= ST_WB;
                    end
                end
                ST_WB: begin
                    if (wb_done) begin
                        irq_pulse <= stat.irq;
                        err_pulse <= is_fault(res_q);
                        idx       <= stat.wrap ? '0 : idx + 1'b1;
                        state     <= ST_CHECK;
                    end
                end
                default: state <= ST_CHECK;
            endcase
        end
    end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int NUM_DESC = 64,
    parameter int POLL_GAP = 16,
    localparam int AW      = $clog2(2 * NUM_DESC),
    localparam int IW      = $clog2(NUM_DESC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sw_wr,
    input  logic [AW-1:0] sw_addr,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   sw_rdata,
    output logic          req_valid,
    output logic [15:0]   req_len,
    output logic [31:0]   req_ptr,
    input  logic          done_valid,
    input  logic [8:0]    done_status,
    output logic          irq_pulse,
    output logic          err_pulse,
    output logic [IW-1:0] cur_idx
);
    logic [31:0] stat_rd, ptr_rd, wb_data;
    logic        wb_req, wb_done, gap_load, gap_expired;
    logic        chk_strobe, chk_hit;

    txr_desc_mem #(.NUM_DESC(NUM_DESC)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .sw_wr    (sw_wr),
        .sw_addr  (sw_addr),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata),
        .idx      (cur_idx),
        .stat_rd  (stat_rd),
        .ptr_rd   (ptr_rd),
        .wb_req   (wb_req),
        .wb_data  (wb_data),
        .wb_done  (wb_done)
    );

    txr_poll_timer #(.POLL_GAP(POLL_GAP)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (!en),
        .load    (gap_load),
        .expired (gap_expired)
    );

    txr_ctrl #(.NUM_DESC(NUM_DESC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .stat        (tx_status_t'(stat_rd)),
        .ptr         (ptr_rd),
        .done_valid  (done_valid),
        .done_res    (tx_result_t'(done_status)),
        .wb_done     (wb_done),
        .gap_expired (gap_expired),
        .idx         (cur_idx),
        .req_valid   (req_valid),
        .req_len     (req_len),
        .req_ptr     (req_ptr),
        .gap_load    (gap_load),
        .wb_req      (wb_req),
        .wb_data     (wb_data),
        .irq_pulse   (irq_pulse),
        .err_pulse   (err_pulse),
        .chk_strobe  (chk_strobe),
        .chk_hit     (chk_hit)
    );
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
    parameter int NUM_DESC = 64,
    parameter int POLL_GAP = 16,
    localparam int IW      = $clog2(NUM_DESC),
    localparam int CW      = $clog2(POLL_GAP + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          req_valid,
    input logic [15:0]   req_len,
    input logic [31:0]   req_ptr,
    input logic          done_valid,
    input logic          irq_pulse,
    input logic          err_pulse,
    input logic [IW-1:0] cur_idx,
    input logic          chk_strobe,
    input logic          chk_hit
);
    logic [CW-1:0] since_miss;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            since_miss <= CW'(POLL_GAP);
        end else if (chk_strobe && !chk_hit) begin
            since_miss <= CW'(1);
        end else if (chk_hit) begin
            since_miss <= CW'(POLL_GAP);
        end else if (since_miss != CW'(POLL_GAP)) begin
            since_miss <= since_miss + 1'b1;
        end
    end

    AST_POLL_GAP: assert property (@(posedge clk) disable iff (rst)
        chk_strobe |-> (since_miss >= CW'(POLL_GAP))); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && req_valid && !done_valid) |=> req_valid); // R3

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (en && req_valid && !done_valid) |=> ($stable(req_len) && $stable(req_ptr))); // R3

    AST_EN_PARK: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!req_valid && cur_idx == '0)); // R9

    AST_IRQ_ONE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse); // R7

    AST_ERR_ONE: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse); // R8

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && cur_idx != $past(cur_idx))
            |-> (cur_idx == '0 || cur_idx == $past(cur_idx) + 1'b1)); // R5
endmodule

bind txr_engine txr_checker #(.NUM_DESC(NUM_DESC), .POLL_GAP(POLL_GAP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .req_ptr    (req_ptr),
    .done_valid (done_valid),
    .irq_pulse  (irq_pulse),
    .err_pulse  (err_pulse),
    .cur_idx    (cur_idx),
    .chk_strobe (chk_strobe),
    .chk_hit    (chk_hit)
);

// File: tb/tb_txr_engine.sv
module tb_txr_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        sw_wr = 1'b0;
    logic [6:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        req_valid;
    logic [15:0] req_len;
    logic [31:0] req_ptr;
    logic        done_valid = 1'b0;
    logic [8:0]  done_status = '0;
    logic        irq_pulse, err_pulse;
    logic [5:0]  cur_idx;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [47:0] exp_q[$];
    bit seen = 0;

    always #2.5 clk = ~clk;

    txr_engine dut (
        .clk(clk), .rst(rst), .en(en),
        .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .req_valid(req_valid), .req_len(req_len), .req_ptr(req_ptr),
        .done_valid(done_valid), .done_status(done_status),
        .irq_pulse(irq_pulse), .err_pulse(err_pulse), .cur_idx(cur_idx)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every new request.
    always @(negedge clk) begin
        if (!rst && req_valid && !seen) begin
            seen = 1;
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected request", {req_len, req_ptr}, 48'h0);
            end else begin
                logic [47:0] e;
                e = exp_q.pop_front();
                check({req_len, req_ptr} == e, "R3 request fields", {req_len, req_ptr}, e);
            end
        end
        if (!req_valid) seen = 0;
    end

    task automatic push_exp(input logic [15:0] len, input logic [31:0] ptr);
        exp_q.push_back({len, ptr});
    endtask

    task automatic sw_write(input logic [6:0] a, input logic [31:0] d);
        sw_wr = 1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_wr = 0;
    endtask

    task automatic sw_read(input logic [6:0] a, output logic [31:0] d);
        sw_addr = a;
        #1;
        d = sw_rdata;
    endtask

    task automatic serve(input logic [8:0] st, input logic xirq, input logic xerr, input bit collide);
        int n = 0;
        while (!req_valid && n < 200) begin @(negedge clk); n++; end
        check(req_valid, "R3 request raised", req_valid, 1);
        repeat (2) @(negedge clk);
        check(req_valid, "R3 request held", req_valid, 1);
        done_valid = 1; done_status = st;
        @(negedge clk);
        done_valid = 0;
        if (collide) begin
            sw_wr = 1; sw_addr = 7'd11; sw_wdata = 32'h0000_5A5A;
            @(negedge clk);
            sw_wr = 0;
            check(!irq_pulse && !err_pulse, "R10 write-back deferred", {irq_pulse, err_pulse}, 0);
        end
        @(negedge clk);
        check(irq_pulse == xirq, "R7 irq pulse", irq_pulse, xirq);
        check(err_pulse == xerr, "R8 err pulse", err_pulse, xerr);
        @(negedge clk);
        check(!irq_pulse && !err_pulse, "R7 R8 single-cycle pulses", {irq_pulse, err_pulse}, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        int hits;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check(!req_valid && !irq_pulse && !err_pulse && cur_idx == 0, "R1 reset outputs",
              {req_valid, irq_pulse, err_pulse, cur_idx}, 0);
        sw_read(7'd4, d);
        check(d == 0, "R1 memory cleared", d, 0);

        // Build three descriptors, enable low
        sw_write(7'd0, 32'h0040_C000); sw_write(7'd1, 32'h0000_1000);
        sw_write(7'd2, 32'h0064_8000); sw_write(7'd3, 32'h0000_2000);
        sw_write(7'd4, 32'h003C_F800); sw_write(7'd5, 32'h0000_3000);
        sw_read(7'd3, d);
        check(d == 32'h0000_2000, "R2 pointer readback", d, 32'h0000_2000);
        sw_read(7'd0, d);
        check(d == 32'h0040_C000, "R2 status readback", d, 32'h0040_C000);

        hits = 0;
        repeat (20) begin @(negedge clk); if (req_valid) hits++; end
        check(hits == 0 && cur_idx == 0, "R9 disabled idle", hits, 0);

        push_exp(16'd64, 32'h1000);
        push_exp(16'd100, 32'h2000);
        push_exp(16'd60, 32'h3000);
        en = 1;

        serve(9'h000, 1, 0, 0);
        sw_read(7'd0, d);
        check(d == 32'h0040_4000, "R4 ready cleared", d, 32'h0040_4000);
        check(cur_idx == 1, "R5 increment", cur_idx, 1);

        serve(9'h0F0, 0, 0, 0);
        sw_read(7'd2, d);
        check(d == 32'h0064_00F0, "R4 retry count written", d, 32'h0064_00F0);

        serve(9'h105, 1, 1, 1);
        check(cur_idx == 0, "R5 wrap to 0", cur_idx, 0);
        sw_read(7'd4, d);
        check(d == 32'h003C_7905, "R4 control bits kept", d, 32'h003C_7905);
        sw_read(7'd11, d);
        check(d == 32'h0000_5A5A, "R10 software write kept", d, 32'h0000_5A5A);

        // R6: descriptor 1 ready, 0 not: nothing may be served
        sw_write(7'd2, 32'h0064_8000);
        hits = 0;
        repeat (60) begin @(negedge clk); if (req_valid) hits++; end
        check(hits == 0 && cur_idx == 0, "R6 no skip ahead", hits, 0);

        // R6: poll phase after enable
        en = 0;
        @(negedge clk);
        en = 1;
        @(negedge clk);
        push_exp(16'd64, 32'h1000);
        push_exp(16'd100, 32'h2000);
        sw_write(7'd0, 32'h0040_C000);
        n = 0;
        while (!req_valid && n < 100) begin @(negedge clk); n++; end
        check(n == 15, "R6 poll interval", n, 15);

        serve(9'h000, 1, 0, 0);
        serve(9'h008, 0, 1, 0);
        check(cur_idx == 2, "R5 index after two", cur_idx, 2);

        en = 0;
        @(negedge clk);
        check(cur_idx == 0 && !req_valid, "R9 enable low parks", {req_valid, cur_idx}, 0);
        check(exp_q.size() == 0, "R3 all requests seen", exp_q.size(), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule